// File: doc/BRIEF.md
# Counting Register-Write Scoreboard

This block guards the general-purpose register file of a pipeline that accepts instructions in program order but lets them execute and finish in any order. Operands come only from the register file, because there is no bypass network. Every register therefore carries a small up/down count of the writes still in flight. An instruction at decode may read a register only when that count is zero. When the count for any enabled source is nonzero, the decode stage is held.

Write-after-write order is kept with a pair of wrapping tickets per register. At decode, a writer takes the register's current issue ticket, and that ticket then advances. A finished result arrives on one of several completion ports and waits in a one-entry holding slot on that port. It is allowed to write the register file only when its ticket equals the register's retire ticket. A grant decrements the count and advances the retire ticket. Results for different registers may be granted in the same cycle.

Top module: `regsb_scoreboard`

## Requirements
- R1: After reset, every count and ticket is zero, every completion port is ready, and no write grant is asserted.
- R2: An accepted decode with `dec_wr_en` high adds one to the count of `dec_dst`, so later readers of that register are held.
- R3: While `dec_valid` is high, `dec_stall` is high when an enabled source (`dec_src_a_en`/`dec_src_b_en`) names a register whose count is nonzero. A source whose enable is low never causes a stall.
- R4: A writing decode stalls when the count of its destination is already 7, which is the largest 3-bit value.
- R5: `dec_ticket` shows the destination's issue ticket. This equals the number of writers to that register accepted since reset, modulo 8.
- R6: A result held in a port slot is granted only when its ticket equals the retire ticket of its register. Until it is granted, that port's `cmp_ready` is low and the slot keeps its contents.
- R7: Each grant takes one from the register's count. Once the count reaches zero, a reader of that register is accepted in the next cycle.
- R8: If an accepted writing decode and a grant hit the same register in the same cycle, the count does not change.
- R9: Eligible results on different ports that target different registers are all granted in the same cycle.
- R10: `dec_stall` is low whenever `dec_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | An instruction is present at decode |
| dec_wr_en | input | 1 | The instruction writes a register |
| dec_dst | input | IDX_W | Destination register index |
| dec_src_a | input | IDX_W | First source register index |
| dec_src_a_en | input | 1 | First source is read |
| dec_src_b | input | IDX_W | Second source register index |
| dec_src_b_en | input | 1 | Second source is read |
| dec_stall | output | 1 | Decode must hold this instruction |
| dec_ticket | output | TKT_W | Ticket given to the writer at decode |
| cmp_valid | input | NPORT | A finished result is offered, one bit per port |
| cmp_dst | input | NPORT*IDX_W | Destination index per port |
| cmp_ticket | input | NPORT*TKT_W | Write ticket per port |
| cmp_ready | output | NPORT | Port slot can take a result |
| wr_grant | output | NPORT | Register-file write enable per port |
| wr_dst | output | NPORT*IDX_W | Register written by each granted port |

## Verification
The hardest state to reach is a saturated register whose retires come out of ticket order. A later ticket has to sit in one port's slot while an earlier one passes it on the other port. In that same register, a grant also has to land in the exact cycle that a new writer is accepted. The bench first fills one register to seven pending writers. It then offers tickets in the order 3, 1, 2 on two ports and checks the holding and ready behaviour. It next drives a decode in the cycle of a known grant and shows the unchanged count by counting how many further writers are accepted before saturation.

// File: rtl/regsb_pkg.sv
package regsb_pkg;
  localparam int unsigned SB_NREG  = 16;
  localparam int unsigned SB_CNT_W = 3;
  localparam int unsigned SB_TKT_W = 3;
  localparam int unsigned SB_NPORT = 2;
endpackage

// File: rtl/regsb_entry.sv
module regsb_entry #(
  parameter int CNT_W = 3,
  parameter int TKT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic [TKT_W-1:0] iss_tkt,
  output logic [TKT_W-1:0] ret_tkt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [TKT_W-1:0] iss_q, iss_d, ret_q, ret_d;

  always_comb begin
    cnt_d = cnt_q;
    case ({inc, dec})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
    iss_d = inc ? iss_q + 1'b1 : iss_q;
    ret_d = dec ? ret_q + 1'b1 : ret_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      iss_q <= '0;
      ret_q <= '0;
    end else begin
      if (inc || dec) cnt_q <= cnt_d;
      if (inc)        iss_q <= iss_d;
      if (dec)        ret_q <= ret_d;
    end
  end

  assign cnt     = cnt_q;
  assign iss_tkt = iss_q;
  assign ret_tkt = ret_q;

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> cnt_q != CNT_MAX);
  a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> cnt_q != '0);
  a_r8_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && dec) |=> cnt_q == $past(cnt_q));
  a_r2_count_matches_tickets: assert property (@(posedge clk) disable iff (!rst_n)
    TKT_W'(iss_q - ret_q) == TKT_W'(cnt_q));
endmodule

// File: rtl/regsb_slot.sv
module regsb_slot #(
  parameter int IDX_W = 4,
  parameter int TKT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [IDX_W-1:0] in_dst,
  input  logic [TKT_W-1:0] in_tkt,
  input  logic             grant,
  output logic             ready,
  output logic             held,
  output logic [IDX_W-1:0] dst,
  output logic [TKT_W-1:0] tkt
);
  logic             held_q, held_d, load;
  logic [IDX_W-1:0] dst_q;
  logic [TKT_W-1:0] tkt_q;

  always_comb begin
    ready  = !held_q || grant;
    load   = in_valid && ready;
    held_d = load || (held_q && !grant);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      dst_q  <= '0;
      tkt_q  <= '0;
    end else begin
      held_q <= held_d;
      if (load) begin
        dst_q <= in_dst;
        tkt_q <= in_tkt;
      end
    end
  end

  assign held = held_q;
  assign dst  = dst_q;
  assign tkt  = tkt_q;

  a_r6_wait_keeps_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && !grant) |=> (held_q && $stable(dst_q) && $stable(tkt_q)));
  a_r6_grant_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> held_q);
endmodule

// File: rtl/regsb_scoreboard.sv
module regsb_scoreboard
  import regsb_pkg::*;
#(
  parameter  int NREG  = SB_NREG,
  parameter  int CNT_W = SB_CNT_W,
  parameter  int TKT_W = SB_TKT_W,
  parameter  int NPORT = SB_NPORT,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   dec_valid,
  input  logic                   dec_wr_en,
  input  logic [IDX_W-1:0]       dec_dst,
  input  logic [IDX_W-1:0]       dec_src_a,
  input  logic                   dec_src_a_en,
  input  logic [IDX_W-1:0]       dec_src_b,
  input  logic                   dec_src_b_en,
  output logic                   dec_stall,
  output logic [TKT_W-1:0]       dec_ticket,
  input  logic [NPORT-1:0]       cmp_valid,
  input  logic [NPORT*IDX_W-1:0] cmp_dst,
  input  logic [NPORT*TKT_W-1:0] cmp_ticket,
  output logic [NPORT-1:0]       cmp_ready,
  output logic [NPORT-1:0]       wr_grant,
  output logic [NPORT*IDX_W-1:0] wr_dst
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt     [NREG];
  logic [TKT_W-1:0] iss_tkt [NREG];
  logic [TKT_W-1:0] ret_tkt [NREG];
  logic [NREG-1:0]  inc_v, dec_v;

  logic [NPORT-1:0] s_held, grant;
  logic [IDX_W-1:0] s_dst [NPORT];
  logic [TKT_W-1:0] s_tkt [NPORT];

  logic busy_a, busy_b, dst_full, hold, accept;

  // Decode gate
  always_comb begin
    busy_a     = dec_src_a_en && (cnt[dec_src_a] != '0);
    busy_b     = dec_src_b_en && (cnt[dec_src_b] != '0);
    dst_full   = dec_wr_en && (cnt[dec_dst] == CNT_MAX);
    hold       = busy_a || busy_b || dst_full;
    dec_stall  = dec_valid && hold;
    accept     = dec_valid && !hold;
    dec_ticket = iss_tkt[dec_dst];
  end

  // Per-register counters and tickets
  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic hit;
    always_comb begin
      hit = 1'b0;
      for (int p = 0; p < NPORT; p++)
        if (grant[p] && (s_dst[p] == IDX_W'(r))) hit = 1'b1;
    end
    assign dec_v[r] = hit;
    assign inc_v[r] = accept && dec_wr_en && (dec_dst == IDX_W'(r));

    regsb_entry #(.CNT_W(CNT_W), .TKT_W(TKT_W)) u_entry (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc     (inc_v[r]),
      .dec     (dec_v[r]),
      .cnt     (cnt[r]),
      .iss_tkt (iss_tkt[r]),
      .ret_tkt (ret_tkt[r])
    );
  end

  // Completion ports with holding slots
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    regsb_slot #(.IDX_W(IDX_W), .TKT_W(TKT_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (cmp_valid[p]),
      .in_dst   (cmp_dst[p*IDX_W +: IDX_W]),
      .in_tkt   (cmp_ticket[p*TKT_W +: TKT_W]),
      .grant    (grant[p]),
      .ready    (cmp_ready[p]),
      .held     (s_held[p]),
      .dst      (s_dst[p]),
      .tkt      (s_tkt[p])
    );
    assign grant[p]                  = s_held[p] && (s_tkt[p] == ret_tkt[s_dst[p]]);
    assign wr_dst[p*IDX_W +: IDX_W]  = s_dst[p];

    for (genvar q = p + 1; q < NPORT; q++) begin : g_pair
      a_r9_distinct_targets: assert property (@(posedge clk) disable iff (!rst_n)
        (grant[p] && grant[q]) |-> (s_dst[p] != s_dst[q]));
    end
  end

  assign wr_grant = grant;

  a_r3_src_a_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dec_src_a_en) |-> cnt[dec_src_a] == '0);
  a_r3_src_b_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dec_src_b_en) |-> cnt[dec_src_b] == '0);
endmodule

// File: tb/tb_regsb_scoreboard.sv
module tb_regsb_scoreboard;
  localparam int NREG = 16, TKT_W = 3, NPORT = 2, IDX_W = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                   rst_n;
  logic                   dec_valid, dec_wr_en, dec_src_a_en, dec_src_b_en;
  logic [IDX_W-1:0]       dec_dst, dec_src_a, dec_src_b;
  logic                   dec_stall;
  logic [TKT_W-1:0]       dec_ticket;
  logic [NPORT-1:0]       cmp_valid, cmp_ready, wr_grant;
  logic [NPORT*IDX_W-1:0] cmp_dst, wr_dst;
  logic [NPORT*TKT_W-1:0] cmp_ticket;

  regsb_scoreboard dut (
    .clk(clk), .rst_n(rst_n),
    .dec_valid(dec_valid), .dec_wr_en(dec_wr_en), .dec_dst(dec_dst),
    .dec_src_a(dec_src_a), .dec_src_a_en(dec_src_a_en),
    .dec_src_b(dec_src_b), .dec_src_b_en(dec_src_b_en),
    .dec_stall(dec_stall), .dec_ticket(dec_ticket),
    .cmp_valid(cmp_valid), .cmp_dst(cmp_dst), .cmp_ticket(cmp_ticket),
    .cmp_ready(cmp_ready), .wr_grant(wr_grant), .wr_dst(wr_dst)
  );

  int n_chk = 0, n_err = 0;
  int m_cnt [NREG];
  int m_iss [NREG];
  int m_ret [NREG];

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic dec_cycle(int dst, bit wen, int sa, bit ea, int sb, bit eb, string req);
    bit exp_st;
    @(negedge clk);
    dec_valid = 1'b1; dec_wr_en = wen; dec_dst = dst[3:0];
    dec_src_a = sa[3:0]; dec_src_a_en = ea; dec_src_b = sb[3:0]; dec_src_b_en = eb;
    #1;
    exp_st = (ea && m_cnt[sa] != 0) || (eb && m_cnt[sb] != 0) || (wen && m_cnt[dst] == 7);
    chk(req, int'(dec_stall), int'(exp_st));
    if (wen && !exp_st) begin
      chk("R5 ticket", int'(dec_ticket), m_iss[dst] % 8);
      m_iss[dst]++;
      m_cnt[dst]++;
    end
    @(posedge clk); #1;
    dec_valid = 1'b0; dec_src_a_en = 1'b0; dec_src_b_en = 1'b0;
  endtask

  task automatic cmp_cycle(int p, int dst, int tkt, bit exp_rdy, string req);
    @(negedge clk);
    cmp_valid[p] = 1'b1;
    cmp_dst[p*IDX_W +: IDX_W] = dst[3:0];
    cmp_ticket[p*TKT_W +: TKT_W] = tkt[2:0];
    #1;
    chk(req, int'(cmp_ready[p]), int'(exp_rdy));
    @(posedge clk); #1;
    cmp_valid[p] = 1'b0;
  endtask

  task automatic grant_chk(int p, int dst, bit exp, string req);
    chk(req, int'(wr_grant[p]), int'(exp));
    if (exp) begin
      chk(req, int'(wr_dst[p*IDX_W +: IDX_W]), dst);
      @(posedge clk); #1;
      m_cnt[dst]--;
      m_ret[dst]++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREG; i++) begin m_cnt[i] = 0; m_iss[i] = 0; m_ret[i] = 0; end
    rst_n = 1'b0; dec_valid = 1'b0; dec_wr_en = 1'b0; dec_dst = '0;
    dec_src_a = '0; dec_src_a_en = 1'b0; dec_src_b = '0; dec_src_b_en = 1'b0;
    cmp_valid = '0; cmp_dst = '0; cmp_ticket = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 ready0", int'(cmp_ready[0]), 1);
    chk("R1 ready1", int'(cmp_ready[1]), 1);
    chk("R1 grants", int'(wr_grant), 0);
    chk("R1 stall", int'(dec_stall), 0);

    // R2/R3 sweep: add one writer per register, probe every source after each
    for (int r = 0; r < NREG; r++) begin
      dec_cycle(r, 1'b1, 0, 1'b0, 0, 1'b0, "R2 writer");
      for (int s = 0; s < NREG; s++)
        dec_cycle(0, 1'b0, s, (s % 2) == 0, s, (s % 2) == 1, "R3 probe");
    end
    dec_cycle(0, 1'b0, 3, 1'b0, 7, 1'b0, "R3 disabled sources");

    // R10: no stall without valid
    @(negedge clk);
    dec_src_a = 4'd2; dec_src_a_en = 1'b1; dec_valid = 1'b0;
    #1 chk("R10 idle", int'(dec_stall), 0);
    dec_src_a_en = 1'b0;

    // R9/R7: retire pairs on both ports in one cycle
    for (int r = 0; r < NREG; r += 2) begin
      @(negedge clk);
      cmp_valid = 2'b11;
      cmp_dst = {r[3:0] + 4'd1, r[3:0]};
      cmp_ticket = '0;
      #1;
      chk("R9 ready", int'(cmp_ready), 3);
      @(posedge clk); #1;
      cmp_valid = '0;
      chk("R9 grant both", int'(wr_grant), 3);
      chk("R9 dst0", int'(wr_dst[3:0]), r);
      chk("R9 dst1", int'(wr_dst[7:4]), r + 1);
      @(posedge clk); #1;
      m_cnt[r]--; m_ret[r]++; m_cnt[r+1]--; m_ret[r+1]++;
      dec_cycle(0, 1'b0, r, 1'b1, r + 1, 1'b1, "R7 reader after retire");
      if (r + 2 < NREG) dec_cycle(0, 1'b0, r + 2, 1'b1, 0, 1'b0, "R7 still pending");
    end

    // R4: saturate register 5
    for (int k = 0; k < 8; k++) dec_cycle(5, 1'b1, 0, 1'b0, 0, 1'b0, "R4 saturation");
    @(negedge clk);
    dec_dst = 4'd5; dec_wr_en = 1'b1; dec_valid = 1'b0;
    #1 chk("R10 idle full", int'(dec_stall), 0);
    dec_wr_en = 1'b0;

    // R6: out-of-order completion for register 5 (retire ticket 1)
    cmp_cycle(0, 5, 3, 1'b1, "R6 load late ticket");
    grant_chk(0, 5, 1'b0, "R6 late ticket waits");
    chk("R6 ready low while held", int'(cmp_ready[0]), 0);
    cmp_cycle(1, 5, 1, 1'b1, "R6 load ticket 1");
    chk("R6 held slot still blocked", int'(wr_grant[0]), 0);
    grant_chk(1, 5, 1'b1, "R6 ticket 1 granted");
    cmp_cycle(1, 5, 2, 1'b1, "R6 load ticket 2");
    chk("R6 held slot still blocked", int'(wr_grant[0]), 0);
    grant_chk(1, 5, 1'b1, "R6 ticket 2 granted");
    grant_chk(0, 5, 1'b1, "R6 held ticket 3 granted");
    chk("R6 ready restored", int'(cmp_ready[0]), 1);
    chk("R6 no grant", int'(wr_grant[0]), 0);

    // R8: grant and writer decode on register 5 in one cycle
    cmp_cycle(0, 5, 4, 1'b1, "R8 load ticket 4");
    chk("R8 grant", int'(wr_grant[0]), 1);
    dec_valid = 1'b1; dec_wr_en = 1'b1; dec_dst = 4'd5;
    #1;
    chk("R8 decode accepted", int'(dec_stall), 0);
    chk("R5 ticket wrap", int'(dec_ticket), m_iss[5] % 8);
    @(posedge clk); #1;
    dec_valid = 1'b0; dec_wr_en = 1'b0;
    m_iss[5]++; m_ret[5]++;
    for (int k = 0; k < 4; k++) dec_cycle(5, 1'b1, 0, 1'b0, 0, 1'b0, "R8 count unchanged");

    // R6/R7: drain register 5 in ticket order
    for (int k = 0; k < 7; k++) begin
      cmp_cycle(0, 5, (5 + k) % 8, 1'b1, "R6 drain load");
      grant_chk(0, 5, 1'b1, "R6 drain grant");
      dec_cycle(0, 1'b0, 5, 1'b1, 0, 1'b0, "R7 reader during drain");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule